// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block stands between a requester and one DRAM bank. It takes one read or write request at a time, each carrying a row and a column address. It keeps track of whether a row is open and, if so, which one. From that it picks the command sequence the access needs: a column command alone, an activate then a column command, or a precharge, an activate and then a column command. No command leaves the block before every minimum gap that applies to it has passed.

All gaps are counted in clock cycles. They come from five 4-bit configuration inputs:

- read latency
- activate-to-column delay
- precharge-to-activate delay
- activate-to-precharge minimum
- write recovery before precharge

Each accepted request produces a completion pulse with a class code that says whether the row was already open, the bank was closed, or another row had to be closed first. For every read, a data-valid strobe follows the read command after the programmed latency. After an access the row stays open. It is only closed when a request for a different row arrives.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, no command output is asserted, and the bank counts as closed, so the first access is classified as empty.
- R2: A request is taken only in a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the following cycle until the cycle after the column command.
- R3: If the requested row is already open, the column command (`cmd_rd` or `cmd_wr`) is issued in the cycle after acceptance, and `done` pulses in that same cycle with `done_class` = 2'b00.
- R4: If no row is open, `cmd_act` is issued in the cycle after acceptance with `cmd_row` equal to the requested row. The column command follows exactly `cfg_trcd` cycles later, and `done_class` = 2'b01.
- R5: If a different row is open, `cmd_pre` is issued first, `cmd_act` follows exactly `cfg_trp` cycles later, and the column command comes `cfg_trcd` cycles after that, with `done_class` = 2'b10. Read data is therefore due trp+trcd+cl cycles after the precharge.
- R6: `cmd_pre` is issued no earlier than `cfg_tras` cycles after the activate of the open row. It is issued in the first cycle where every gap allows it, and never before the cycle after acceptance.
- R7: `cmd_pre` is issued no earlier than `cfg_twr` cycles after the last `cmd_wr`.
- R8: A configuration value of 0 behaves exactly like a value of 1.
- R9: For every `cmd_rd`, `rd_valid` pulses for one cycle exactly `cfg_cl` cycles later.
- R10: At most one of `cmd_act`, `cmd_pre`, `cmd_rd` and `cmd_wr` is asserted in any cycle. `cmd_col` carries the request's column during the column command.
- R11: Configuration inputs are captured in the acceptance cycle. Changes made while a request is in progress do not affect that request's timing.
- R12: After an access the row stays open, and later requests to the same row are classified as hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cfg_cl | input | TW | Read latency in cycles |
| cfg_trcd | input | TW | Activate-to-column gap |
| cfg_trp | input | TW | Precharge-to-activate gap |
| cfg_tras | input | TW | Activate-to-precharge minimum |
| cfg_twr | input | TW | Write-to-precharge minimum |
| cmd_act | output | 1 | Activate command strobe |
| cmd_pre | output | 1 | Precharge command strobe |
| cmd_rd | output | 1 | Read column command strobe |
| cmd_wr | output | 1 | Write column command strobe |
| cmd_row | output | ROW_W | Row address for activate |
| cmd_col | output | COL_W | Column address for column command |
| rd_valid | output | 1 | Read data due this cycle |
| done | output | 1 | Request completed |
| done_class | output | 2 | 00 hit, 01 empty, 10 conflict |

## Verification
The bench chains accesses so that each precharge rule in turn is the one that binds. In one case the activate-to-precharge minimum is the limit. In another a recent write holds the precharge back. A design that checked only one of these rules would precharge a few cycles early, and the precharge cycle would not match. An all-zero configuration checks that no gap collapses to zero or wraps around, which would show up as a missing strobe or as data landing at the wrong time. A configuration change during an access checks that parameters are captured only when a request is accepted. A design that read them live would stretch that access to the new, larger gaps.

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [TW-1:0]    cfg_cl,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_tras,
  input  logic [TW-1:0]    cfg_twr,
  output logic             cmd_act,
  output logic             cmd_pre,
  output logic             cmd_rd,
  output logic             cmd_wr,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             rd_valid,
  output logic             done,
  output logic [1:0]       done_class
);
  localparam logic [TW-1:0] SAT = '1;
  localparam int PW = 1 << TW;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_COL} st_t;

  st_t              st;
  logic             row_open, r_write;
  logic [ROW_W-1:0] open_row, r_row;
  logic [COL_W-1:0] r_col;
  logic [1:0]       r_class;
  logic [TW-1:0]    p_cl, p_trcd, p_trp, p_tras, p_twr;
  logic [TW-1:0]    since_act, since_pre, since_wr;
  logic [PW-1:0]    rd_pipe;
  logic             accept, col_go;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;

  assign cmd_pre = (st == S_PRE) && (since_act >= p_tras) && (since_wr >= p_twr);
  assign cmd_act = (st == S_ACT) && (since_pre >= p_trp);
  assign col_go  = (st == S_COL) && (since_act >= p_trcd);
  assign cmd_rd  = col_go && !r_write;
  assign cmd_wr  = col_go && r_write;

  assign cmd_row    = r_row;
  assign cmd_col    = r_col;
  assign done       = col_go;
  assign done_class = r_class;
  assign rd_valid   = rd_pipe[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      row_open <= 1'b0;
      open_row <= '0;
      r_write  <= 1'b0;
      r_row    <= '0;
      r_col    <= '0;
      r_class  <= 2'b00;
      p_cl     <= TW'(1);
      p_trcd   <= TW'(1);
      p_trp    <= TW'(1);
      p_tras   <= TW'(1);
      p_twr    <= TW'(1);
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          r_write <= req_write;
          r_row   <= req_row;
          r_col   <= req_col;
          p_cl    <= at_least_one(cfg_cl);
          p_trcd  <= at_least_one(cfg_trcd);
          p_trp   <= at_least_one(cfg_trp);
          p_tras  <= at_least_one(cfg_tras);
          p_twr   <= at_least_one(cfg_twr);
          if (row_open && open_row == req_row) begin
            r_class <= 2'b00;
            st      <= S_COL;
          end else if (!row_open) begin
            r_class <= 2'b01;
            st      <= S_ACT;
          end else begin
            r_class <= 2'b10;
            st      <= S_PRE;
          end
        end
        S_PRE: if (cmd_pre) begin
          row_open <= 1'b0;
          st       <= S_ACT;
        end
        S_ACT: if (cmd_act) begin
          row_open <= 1'b1;
          open_row <= r_row;
          st       <= S_COL;
        end
        S_COL: if (col_go) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
      since_wr  <= SAT;
      rd_pipe   <= '0;
    end else begin
      since_act <= cmd_act ? TW'(1) : (since_act == SAT ? SAT : since_act + 1'b1);
      since_pre <= cmd_pre ? TW'(1) : (since_pre == SAT ? SAT : since_pre + 1'b1);
      since_wr  <= cmd_wr  ? TW'(1) : (since_wr  == SAT ? SAT : since_wr  + 1'b1);
      rd_pipe   <= (rd_pipe >> 1) | (cmd_rd ? (PW'(1) << (p_cl - 1'b1)) : '0);
    end
  end

  // R10: one command per cycle
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_pre, cmd_rd, cmd_wr}));

  // R5: precharge only closes an open row
  a_r5_pre_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> row_open);

  // R4: activate only into a closed bank
  a_r4_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> !row_open);

  // R2: ready drops after a request is taken
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R2: ready returns after the column command
  a_r2_ready_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> req_ready);

  // R12: a column command always targets an open row
  a_r12_col_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |-> (row_open && open_row == cmd_row));

  // R6: no precharge in the cycle right after an activate
  a_r6_no_pre_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |=> !cmd_pre);
endmodule

// File: tb/sim_dram_bank_seq.sv
module sim_dram_bank_seq;
  localparam int ROW_W = 13, COL_W = 10, TW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [TW-1:0] cfg_cl = 3, cfg_trcd = 2, cfg_trp = 3, cfg_tras = 6, cfg_twr = 4;
  logic req_ready, cmd_act, cmd_pre, cmd_rd, cmd_wr, rd_valid, done;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [1:0] done_class;

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
    .cfg_twr(cfg_twr), .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_valid(rd_valid),
    .done(done), .done_class(done_class));

  always #10 clk = ~clk;

  int cyc = 0;
  int n_chk = 0, n_fail = 0, multi_cmd = 0;
  int t_act = -1, t_pre = -1, t_done = -1, t_rdv = -1;
  int act_row = -1, done_col = -1, done_cls = -1;
  bit finished = 0;

  bit model_open = 0;
  int model_row = -1, last_act = -100, last_wr = -100;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (int'(cmd_act) + int'(cmd_pre) + int'(cmd_rd) + int'(cmd_wr) > 1) multi_cmd++;
      if (cmd_act) begin t_act = cyc; act_row = int'(cmd_row); end
      if (cmd_pre) t_pre = cyc;
      if (done) begin t_done = cyc; done_cls = int'(done_class); done_col = int'(cmd_col); end
      if (rd_valid) t_rdv = cyc;
    end
  end

  function automatic int eff(input logic [TW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic access(input bit wr, input int row, input int col,
                        input logic [TW-1:0] cl, trcd, trp, tras, twr,
                        input bit perturb, input string tag);
    int a, cls, epre, eact, ecol, guard;
    cls = (model_open && row == model_row) ? 0 : (!model_open ? 1 : 2);
    t_act = -1; t_pre = -1; t_done = -1;
    @(negedge clk);
    cfg_cl = cl; cfg_trcd = trcd; cfg_trp = trp; cfg_tras = tras; cfg_twr = twr;
    req_write = wr; req_row = ROW_W'(row); req_col = COL_W'(col); req_valid = 1;
    guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    a = cyc;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, {tag, " R2 ready low while busy"}, int'(req_ready), 0);
    if (perturb) begin
      cfg_cl = 15; cfg_trcd = 15; cfg_trp = 15; cfg_tras = 15; cfg_twr = 15;
    end
    epre = -1; eact = -1;
    if (cls == 2) begin
      epre = imax(a + 1, imax(last_act + eff(tras), last_wr + eff(twr)));
      eact = epre + eff(trp);
      ecol = eact + eff(trcd);
    end else if (cls == 1) begin
      eact = a + 1;
      ecol = eact + eff(trcd);
    end else ecol = a + 1;
    guard = 0;
    while (t_done < 0 && guard < 200) begin @(negedge clk); guard++; end
    chk(t_done == ecol, {tag, " column command cycle (R3/R4/R5)"}, t_done - a, ecol - a);
    chk(done_cls == cls, {tag, " class code (R3/R4/R5/R12)"}, done_cls, cls);
    chk(done_col == col, {tag, " R10 column address"}, done_col, col);
    if (cls == 2) chk(t_pre == epre, {tag, " precharge cycle (R5/R6/R7)"}, t_pre - a, epre - a);
    if (cls >= 1) begin
      chk(t_act == eact, {tag, " activate cycle (R4/R5)"}, t_act - a, eact - a);
      chk(act_row == row, {tag, " R4 activate row"}, act_row, row);
    end
    if (!wr) begin
      guard = 0;
      while (cyc <= ecol + eff(cl) + 1 && guard < 200) begin @(negedge clk); guard++; end
      chk(t_rdv == ecol + eff(cl), {tag, " R9 read data strobe"}, t_rdv - ecol, eff(cl));
    end
    if (cls >= 1) begin last_act = eact; last_wr = -100; end
    if (wr) last_wr = ecol;
    model_open = 1; model_row = row;
  endtask

  task automatic t_reset();
    chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
    repeat (3) begin
      @(negedge clk);
      chk({cmd_act, cmd_pre, cmd_rd, cmd_wr} == 4'b0, "R1 no command after reset",
          int'({cmd_act, cmd_pre, cmd_rd, cmd_wr}), 0);
    end
  endtask

  task automatic t_empty_then_hit();
    access(0, 5, 17, 3, 2, 3, 6, 4, 0, "R1 first access empty");
    access(0, 5, 9, 3, 2, 3, 6, 4, 0, "R3 hit read");
    access(0, 5, 10, 5, 2, 3, 6, 4, 0, "R12 page stays open");
  endtask

  task automatic t_conflict_tras();
    access(0, 9, 1, 3, 2, 3, 6, 4, 0, "R5 conflict read");
    access(0, 12, 2, 2, 1, 2, 12, 1, 0, "R6 tras binds");
  endtask

  task automatic t_write_recovery();
    access(1, 12, 3, 2, 1, 2, 1, 1, 0, "R3 hit write");
    access(0, 3, 4, 2, 1, 2, 1, 11, 0, "R7 twr binds");
  endtask

  task automatic t_zero_params();
    access(0, 7, 5, 0, 0, 0, 0, 0, 0, "R8 zero params conflict");
    access(0, 7, 6, 0, 0, 0, 0, 0, 0, "R8 zero params hit");
  endtask

  task automatic t_sampling();
    access(0, 100, 8, 4, 3, 2, 2, 2, 1, "R11 cfg changed while busy");
    access(1, 200, 9, 4, 3, 2, 2, 2, 1, "R11 cfg changed on write");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty_then_hit();
    t_conflict_tras();
    t_write_recovery();
    t_zero_params();
    t_sampling();
    repeat (20) @(negedge clk);
    chk(multi_cmd == 0, "R10 one command per cycle", multi_cmd, 0);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_up();
  end
endmodule